// File: doc/BRIEF.md
# Packet Timestamp Capture Latch

This block freezes the running system time when a precision-time packet passes the MAC, separately for the transmit and receive directions. A parser upstream gives a one-cycle event strobe for each direction. For receive packets it also supplies the decoded ethertype, UDP destination port, protocol version and message type. Each direction holds a single 64-bit stamp and a valid flag. Once a stamp is held, the direction is locked until software reads the upper stamp word. Events that arrive while the direction is locked are dropped and recorded in a sticky overrun flag.

Receive capture is qualified by a mode field, a match register and an ethertype filter. The mode field chooses one of two schemes. The first stamps one selected version-1 message type carried over UDP. The second stamps every version-2 event message, which includes the path-delay messages, carried over UDP or over layer 2. Software reaches the block through a small word-addressed register bus. Read data is combinational, and a read strobe marks the cycle in which a read takes effect.

Top module: `pkt_stamp_latch`

## Requirements
- R1: After reset, every register reads zero. This covers both control words, the four stamp words, the match register and the ethertype filter.
- R2: When a direction is enabled and unlocked, its event strobe latches `time_now` from the strobe's own cycle. The valid bit (control bit 0) reads 1 from the next cycle. Transmit control is at word 0, with enable in bit 4. Transmit stamp low is at word 2 and high at word 3.
- R3: While valid is set, further events leave the held stamp unchanged and set the sticky overrun bit (control bit 8). Writing 1 to bit 8 clears overrun, and a new overrun in the same cycle takes priority over the clear.
- R4: Reading the low stamp word has no effect on the lock. Reading the high stamp word clears valid, and the next event captures again.
- R5: Writing a control word with enable 0 clears that direction's valid bit and its lock.
- R6: Receive mode 0 (control bits 2:1 = 00) stamps only version-1 UDP packets. The UDP port must equal match register bits 31:16 (word 6), and the message type must equal match bits 7:0. Receive control is at word 1, and the receive stamp is at words 4 (low) and 5 (high).
- R7: Receive mode 2 (bits 2:1 = 10) stamps version-2 packets whose message type is 0 to 3, which includes the path-delay types 2 and 3, when the UDP port matches. Version-2 types of 4 and above are rejected, and so are version-1 packets.
- R8: In mode 2, a layer-2 packet qualifies only when the filter word (word 7) has bit 31 (enable) and bit 30 (stamp) both set and its bits 15:0 equal the packet's ethertype.
- R9: Receive modes 1 and 3 capture nothing. Capturing every packet is not offered.
- R10: A disabled direction ignores its events and sets neither valid nor overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_now | input | 64 | Running system time |
| tx_evt | input | 1 | Transmit event strobe |
| rx_evt | input | 1 | Receive event strobe |
| rx_v2 | input | 1 | Receive packet is protocol version 2 |
| rx_is_udp | input | 1 | Receive packet is carried over UDP |
| rx_udp_port | input | 16 | Decoded UDP destination port |
| rx_is_l2 | input | 1 | Receive packet is carried directly over layer 2 |
| rx_ethertype | input | 16 | Decoded ethertype |
| rx_msg_type | input | 8 | Decoded message type or control field |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |

## Verification
A stamp is readable, and valid reads set, in the cycle after the edge that saw the event strobe. Overrun and the effects of a control write also appear one edge later. Read data depends only on the address and current state, so the bench samples it in the same cycle it drives the address, before the edge that applies the read's side effect. Every stimulus is driven on a falling edge, and the matching read is issued at the following falling edge. Results are therefore always checked one rising edge after the stimulus and never in a cycle where the state is changing.

// File: rtl/pkt_stamp_latch.sv
module pkt_stamp_latch #(
  parameter int TW = 64,
  parameter int DW = 32,
  parameter int AW = 3,
  parameter int PW = 16,
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] time_now,
  input  logic          tx_evt,
  input  logic          rx_evt,
  input  logic          rx_v2,
  input  logic          rx_is_udp,
  input  logic [PW-1:0] rx_udp_port,
  input  logic          rx_is_l2,
  input  logic [15:0]   rx_ethertype,
  input  logic [MW-1:0] rx_msg_type,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata
);
  localparam logic [AW-1:0] A_TXC = 0, A_RXC = 1, A_TXL = 2, A_TXH = 3,
                            A_RXL = 4, A_RXH = 5, A_MAT = 6, A_ETF = 7;

  logic          tx_en, tx_valid, tx_ovr;
  logic          rx_en, rx_valid, rx_ovr;
  logic [1:0]    rx_mode;
  logic [TW-1:0] tx_stamp, rx_stamp;
  logic [DW-1:0] match_q, etf_q;

  wire wr_txc = reg_wr && reg_addr == A_TXC;
  wire wr_rxc = reg_wr && reg_addr == A_RXC;
  wire rd_txh = reg_rd && reg_addr == A_TXH;
  wire rd_rxh = reg_rd && reg_addr == A_RXH;

  wire port_hit = rx_is_udp && rx_udp_port == match_q[DW-1:DW-PW];
  wire l2_hit   = rx_is_l2 && etf_q[DW-1] && etf_q[DW-2] && rx_ethertype == etf_q[15:0];
  wire v1_hit   = rx_mode == 2'b00 && !rx_v2 && port_hit && rx_msg_type == match_q[MW-1:0];
  wire v2_hit   = rx_mode == 2'b10 && rx_v2 && rx_msg_type[MW-1:2] == '0 && (port_hit || l2_hit);

  wire tx_q = tx_evt && tx_en;
  wire rx_q = rx_evt && rx_en && (v1_hit || v2_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_en <= 1'b0; tx_valid <= 1'b0; tx_ovr <= 1'b0; tx_stamp <= '0;
    end else begin
      if (wr_txc) tx_en <= reg_wdata[4];
      if (wr_txc && !reg_wdata[4]) tx_valid <= 1'b0;
      else if (rd_txh) tx_valid <= 1'b0;
      else if (tx_q && !tx_valid) begin
        tx_valid <= 1'b1;
        tx_stamp <= time_now;
      end
      if (tx_q && tx_valid) tx_ovr <= 1'b1;
      else if (wr_txc && reg_wdata[8]) tx_ovr <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_en <= 1'b0; rx_valid <= 1'b0; rx_ovr <= 1'b0; rx_stamp <= '0;
      rx_mode <= 2'b00;
    end else begin
      if (wr_rxc) begin
        rx_en   <= reg_wdata[4];
        rx_mode <= reg_wdata[2:1];
      end
      if (wr_rxc && !reg_wdata[4]) rx_valid <= 1'b0;
      else if (rd_rxh) rx_valid <= 1'b0;
      else if (rx_q && !rx_valid) begin
        rx_valid <= 1'b1;
        rx_stamp <= time_now;
      end
      if (rx_q && rx_valid) rx_ovr <= 1'b1;
      else if (wr_rxc && reg_wdata[8]) rx_ovr <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_q <= '0;
      etf_q   <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_MAT) match_q <= reg_wdata;
      if (reg_addr == A_ETF) etf_q   <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_TXC: begin
        reg_rdata[0] = tx_valid; reg_rdata[4] = tx_en; reg_rdata[8] = tx_ovr;
      end
      A_RXC: begin
        reg_rdata[0] = rx_valid; reg_rdata[2:1] = rx_mode;
        reg_rdata[4] = rx_en;    reg_rdata[8] = rx_ovr;
      end
      A_TXL: reg_rdata = tx_stamp[DW-1:0];
      A_TXH: reg_rdata = tx_stamp[TW-1:DW];
      A_RXL: reg_rdata = rx_stamp[DW-1:0];
      A_RXH: reg_rdata = rx_stamp[TW-1:DW];
      A_MAT: reg_rdata = match_q;
      default: reg_rdata = etf_q;
    endcase
  end
endmodule

module pkt_stamp_latch_chk #(
  parameter int TW = 64,
  parameter int DW = 32,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_evt,
  input logic          rx_evt,
  input logic          tx_en,
  input logic          rx_en,
  input logic          tx_valid,
  input logic          rx_valid,
  input logic          tx_ovr,
  input logic          rx_ovr,
  input logic [TW-1:0] tx_stamp,
  input logic [TW-1:0] rx_stamp,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata
);
  assert_tx_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(tx_evt) && $past(tx_en));
  assert_rx_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(rx_evt) && $past(rx_en));
  assert_tx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> $stable(tx_stamp));
  assert_rx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> $stable(rx_stamp));
  assert_tx_overrun_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_evt && tx_en && tx_valid) |=> tx_ovr);
  assert_tx_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd3) |=> !tx_valid);
  assert_rx_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd5) |=> !rx_valid);
  assert_tx_disable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0 && !reg_wdata[4]) |=> !tx_valid);
  assert_tx_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !tx_valid) |=> !tx_valid);
endmodule

bind pkt_stamp_latch pkt_stamp_latch_chk #(.TW(TW), .DW(DW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .tx_evt(tx_evt), .rx_evt(rx_evt),
  .tx_en(tx_en), .rx_en(rx_en), .tx_valid(tx_valid), .rx_valid(rx_valid),
  .tx_ovr(tx_ovr), .rx_ovr(rx_ovr), .tx_stamp(tx_stamp), .rx_stamp(rx_stamp),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata));

// File: tb/pkt_stamp_latch_tb.sv
module pkt_stamp_latch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] time_now = '0;
  logic        tx_evt = 1'b0, rx_evt = 1'b0, rx_v2 = 1'b0, rx_is_udp = 1'b0, rx_is_l2 = 1'b0;
  logic [15:0] rx_udp_port = '0, rx_ethertype = '0;
  logic [7:0]  rx_msg_type = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pkt_stamp_latch dut_i (.*);

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string req);
    reg_rd = 1'b1; reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic tx_pulse(input logic [63:0] t);
    tx_evt = 1'b1; time_now = t;
    @(negedge clk);
    tx_evt = 1'b0; time_now = ~t;
  endtask

  task automatic rx_pulse(input bit v2, input bit udp, input logic [15:0] port,
                          input bit l2, input logic [15:0] et, input logic [7:0] mt,
                          input logic [63:0] t);
    rx_evt = 1'b1; rx_v2 = v2; rx_is_udp = udp; rx_udp_port = port;
    rx_is_l2 = l2; rx_ethertype = et; rx_msg_type = mt; time_now = t;
    @(negedge clk);
    rx_evt = 1'b0; time_now = ~t;
  endtask

  task automatic t_reset();
    for (int a = 0; a < 8; a++) rd_chk(a[2:0], 32'h0, "R1 reset value");
  endtask

  task automatic t_tx_capture();
    wr(3'd0, 32'h10);
    tx_pulse(64'h1122_3344_5566_7788);
    rd_chk(3'd0, 32'h11, "R2 valid set");
    rd_chk(3'd2, 32'h5566_7788, "R2 stamp low");
    rd_chk(3'd3, 32'h1122_3344, "R2 stamp high");
    rd_chk(3'd0, 32'h10, "R4 high read releases");
  endtask

  task automatic t_tx_lock();
    tx_pulse(64'hA0A0_0001_A0A0_0002);
    tx_pulse(64'hB0B0_0003_B0B0_0004);
    rd_chk(3'd0, 32'h111, "R3 overrun and still valid");
    rd_chk(3'd2, 32'hA0A0_0002, "R3 first stamp kept");
    rd_chk(3'd0, 32'h111, "R4 low read keeps lock");
    rd_chk(3'd3, 32'hA0A0_0001, "R3 first stamp high kept");
    wr(3'd0, 32'h110);
    rd_chk(3'd0, 32'h10, "R3 overrun cleared by write-one");
    tx_pulse(64'hC0C0_0005_C0C0_0006);
    rd_chk(3'd2, 32'hC0C0_0006, "R4 capture after release");
    rd_chk(3'd3, 32'hC0C0_0005, "R4 capture after release high");
  endtask

  task automatic t_tx_disable();
    tx_pulse(64'hD);
    rd_chk(3'd0, 32'h11, "R5 valid before disable");
    wr(3'd0, 32'h0);
    rd_chk(3'd0, 32'h0, "R5 disable clears valid");
    tx_pulse(64'hE);
    rd_chk(3'd0, 32'h0, "R10 disabled ignores event");
    rd_chk(3'd2, 32'hD, "R10 stamp untouched");
    wr(3'd0, 32'h10);
    tx_pulse(64'hF);
    rd_chk(3'd2, 32'hF, "R5 lock released by disable");
    rd_chk(3'd3, 32'h0, "R5 release read");
  endtask

  task automatic t_rx_v1();
    wr(3'd6, {16'd319, 8'h00, 8'h01});
    rd_chk(3'd6, {16'd319, 16'h0001}, "R6 match readback");
    wr(3'd1, 32'h10);
    rx_pulse(1'b0, 1'b1, 16'd319, 1'b0, 16'h0, 8'h00, 64'h11);
    rd_chk(3'd1, 32'h10, "R6 wrong type rejected");
    rx_pulse(1'b0, 1'b1, 16'd320, 1'b0, 16'h0, 8'h01, 64'h12);
    rd_chk(3'd1, 32'h10, "R6 wrong port rejected");
    rx_pulse(1'b1, 1'b1, 16'd319, 1'b0, 16'h0, 8'h01, 64'h13);
    rd_chk(3'd1, 32'h10, "R6 version 2 rejected in mode 0");
    rx_pulse(1'b0, 1'b1, 16'd319, 1'b0, 16'h0, 8'h01, 64'h7777_0000_0000_0014);
    rd_chk(3'd1, 32'h11, "R6 match captured");
    rd_chk(3'd4, 32'h14, "R6 stamp low");
    rd_chk(3'd5, 32'h7777_0000, "R6 stamp high");
    rd_chk(3'd1, 32'h10, "R6 released");
  endtask

  task automatic t_rx_v2();
    wr(3'd1, 32'h14);
    rx_pulse(1'b1, 1'b1, 16'd319, 1'b0, 16'h0, 8'h03, 64'h21);
    rd_chk(3'd1, 32'h15, "R7 path-delay response captured");
    rd_chk(3'd4, 32'h21, "R7 stamp");
    rd_chk(3'd5, 32'h0, "R7 release");
    rx_pulse(1'b1, 1'b1, 16'd319, 1'b0, 16'h0, 8'h08, 64'h22);
    rd_chk(3'd1, 32'h14, "R7 general message rejected");
    rx_pulse(1'b0, 1'b1, 16'd319, 1'b0, 16'h0, 8'h01, 64'h23);
    rd_chk(3'd1, 32'h14, "R7 version 1 rejected");
    rx_pulse(1'b1, 1'b0, 16'd0, 1'b1, 16'h88F7, 8'h02, 64'h24);
    rd_chk(3'd1, 32'h14, "R8 layer 2 rejected with filter off");
    wr(3'd7, 32'h8000_88F7);
    rx_pulse(1'b1, 1'b0, 16'd0, 1'b1, 16'h88F7, 8'h02, 64'h25);
    rd_chk(3'd1, 32'h14, "R8 rejected without stamp bit");
    wr(3'd7, 32'hC000_88F7);
    rx_pulse(1'b1, 1'b0, 16'd0, 1'b1, 16'h88F8, 8'h00, 64'h26);
    rd_chk(3'd1, 32'h14, "R8 wrong ethertype rejected");
    rx_pulse(1'b1, 1'b0, 16'd0, 1'b1, 16'h88F7, 8'h00, 64'h27);
    rd_chk(3'd1, 32'h15, "R8 layer 2 captured");
    rd_chk(3'd4, 32'h27, "R8 stamp");
    rd_chk(3'd5, 32'h0, "R8 release");
  endtask

  task automatic t_rx_unsupported();
    wr(3'd1, 32'h12);
    rx_pulse(1'b0, 1'b1, 16'd319, 1'b0, 16'h0, 8'h01, 64'h31);
    rx_pulse(1'b1, 1'b1, 16'd319, 1'b0, 16'h0, 8'h00, 64'h32);
    rd_chk(3'd1, 32'h12, "R9 mode 1 captures nothing");
    wr(3'd1, 32'h16);
    rx_pulse(1'b0, 1'b1, 16'd319, 1'b0, 16'h0, 8'h01, 64'h33);
    rx_pulse(1'b1, 1'b0, 16'd0, 1'b1, 16'h88F7, 8'h00, 64'h34);
    rd_chk(3'd1, 32'h16, "R9 mode 3 captures nothing");
    wr(3'd1, 32'h04);
    rx_pulse(1'b1, 1'b1, 16'd319, 1'b0, 16'h0, 8'h00, 64'h35);
    rd_chk(3'd1, 32'h04, "R10 disabled receive ignores event");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx_capture();
    t_tx_lock();
    t_tx_disable();
    t_rx_v1();
    t_rx_v2();
    t_rx_unsupported();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule